// File: doc/BRIEF.md
# Programmable Baud Rate Time-Constant Generator

This block turns a 16-bit time constant into a bit-rate clock. Software writes the constant as two bytes. It then selects where the input ticks come from and sets a run bit. The input is either every system clock cycle or each rising edge of an external clock pin. A down-counter is loaded with the constant plus one and counts input ticks. When a tick arrives with the count already at zero, three things happen: the output clock toggles, the count reloads, and a one-cycle zero-count event is raised. The output therefore has a 50% duty cycle and a period of 2 × (TC + 2) input ticks. To reach a rate `bps` from an input frequency `f`, choose TC = floor((f + bps) / (2 × bps)) − 2.

A small register window provides the controls and readback, and an optional interrupt request follows each zero-count event. The counter runs under a three-state controller:
- **HOLD** (run bit clear): the counter and the output clock keep their values.
- **LOAD**: entered from HOLD when the run bit is seen set. It loads the counter.
- **RUN**: counts ticks.

The transitions are named as follows:
- HOLD→LOAD is `start`.
- LOAD→RUN is `go`.
- RUN→RUN is `count`. It also covers the reload on each zero event.
- LOAD→HOLD and RUN→HOLD are both `stop`, taken when the run bit is clear.

Top module: `baud_tc_gen`

## Requirements
- R1: Address 12 holds TC bits 7:0 and address 13 holds TC bits 15:8. Both read back as written. Address 14 keeps bit 0 (run) and bit 1 (source select), and address 15 keeps bit 1 (zero interrupt enable). Every other bit of these addresses reads 0. Any address other than 0, 12, 13, 14 and 15 reads 0.
- R2: With run = 1 and source = 1 (system clock), consecutive zero-count events are TC + 2 cycles apart. The output clock toggles exactly on each event, so it is high for TC + 2 cycles in a period of 2 × (TC + 2) cycles.
- R3: At the extremes of the constant, TC = 0 gives events every 2 cycles (output period 4), and TC = 0xFFFE gives events 65536 cycles apart.
- R4: While run = 0, no zero-count event occurs and the output clock keeps its level.
- R5: When run changes from 0 to 1, the counter reloads. The first event appears on the output TC + 4 system cycles after the clock edge that accepts the write.
- R6: A TC write made during a countdown does not change that countdown. The new value applies from the next reload.
- R7: With source = 0, each rising edge of `ext_clk` is one input tick, after a SYNC_STAGES-deep synchronizer. Events are spaced (TC + 2) × (external period) system cycles apart.
- R8: `zero_pulse_o` is high for exactly one cycle per event. Address 0 bit 1 reads 1 in that cycle and 0 otherwise, and the other bits of address 0 read 0.
- R9: `irq_o` is high in the cycle of an event if and only if address 15 bit 1 is set.
- R10: After reset, every register is 0, `brg_clk_o` is 0, no event is raised, and all reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External input clock pin, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Combinational read data |
| brg_clk_o | output | 1 | Generated bit-rate clock |
| zero_pulse_o | output | 1 | One-cycle zero-count event |
| irq_o | output | 1 | Zero-count interrupt request |

## Verification
The bench builds the block with its defaults: 8-bit bytes, hence a 16-bit constant, and a 2-stage synchronizer. This puts the full 0 to 0xFFFE range of the constant within reach, including the 65536-cycle half period at the top of the range. The external source is driven at one rising edge every 6 system cycles. That makes the spacing in external mode an exact multiple the bench can predict, whatever the synchronizer latency. Randomly chosen constants and register values are mixed with the directed cases TC = 0, TC = 1 and TC = 0xFFFE.

// File: rtl/brg_pkg.sv
package brg_pkg;

    // register window addresses
    localparam int ADDR_STATUS = 0;
    localparam int ADDR_TC_LO  = 12;
    localparam int ADDR_TC_HI  = 13;
    localparam int ADDR_CTRL   = 14;
    localparam int ADDR_IE     = 15;

    // bit positions inside the window
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_SYS_BIT  = 1;
    localparam int IE_ZERO_BIT   = 1;
    localparam int STAT_ZERO_BIT = 1;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } brg_state_e;

endpackage

// File: rtl/brg_regs.sv
module brg_regs
    import brg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    localparam int TC_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              zero_evt,
    output logic [DATA_W-1:0] rd_data,
    output logic [TC_W-1:0]   tc,
    output logic              run_en,
    output logic              src_sys,
    output logic              zero_ie
);

    logic [DATA_W-1:0] tc_lo_q;
    logic [DATA_W-1:0] tc_hi_q;
    logic              run_q;
    logic              sys_q;
    logic              ie_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_lo_q <= '0;
            tc_hi_q <= '0;
            run_q   <= 1'b0;
            sys_q   <= 1'b0;
            ie_q    <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_TC_LO)) tc_lo_q <= wr_data;
            if (wr_addr == ADDR_W'(ADDR_TC_HI)) tc_hi_q <= wr_data;
            if (wr_addr == ADDR_W'(ADDR_CTRL)) begin
                run_q <= wr_data[CTRL_RUN_BIT];
                sys_q <= wr_data[CTRL_SYS_BIT];
            end
            if (wr_addr == ADDR_W'(ADDR_IE)) ie_q <= wr_data[IE_ZERO_BIT];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADDR_STATUS)) begin
            rd_data[STAT_ZERO_BIT] = zero_evt;
        end else if (rd_addr == ADDR_W'(ADDR_TC_LO)) begin
            rd_data = tc_lo_q;
        end else if (rd_addr == ADDR_W'(ADDR_TC_HI)) begin
            rd_data = tc_hi_q;
        end else if (rd_addr == ADDR_W'(ADDR_CTRL)) begin
            rd_data[CTRL_RUN_BIT] = run_q;
            rd_data[CTRL_SYS_BIT] = sys_q;
        end else if (rd_addr == ADDR_W'(ADDR_IE)) begin
            rd_data[IE_ZERO_BIT] = ie_q;
        end
    end

    assign tc      = {tc_hi_q, tc_lo_q};
    assign run_en  = run_q;
    assign src_sys = sys_q;
    assign zero_ie = ie_q;

    // a read of an unmapped address returns zero
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr != ADDR_W'(ADDR_STATUS) && rd_addr != ADDR_W'(ADDR_TC_LO) &&
         rd_addr != ADDR_W'(ADDR_TC_HI) && rd_addr != ADDR_W'(ADDR_CTRL) &&
         rd_addr != ADDR_W'(ADDR_IE)) |-> rd_data == '0); // R1

endmodule

// File: rtl/brg_tick_src.sv
module brg_tick_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic src_sys,
    output logic tick
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   ext_rise;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= ext_clk;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign ext_rise = sync_q[SYNC_STAGES-1] & ~last_q;
    assign tick     = src_sys | ext_rise;

    // a synchronized rising edge never repeats on the next cycle
    AST_EXT_EDGE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rise |=> !ext_rise); // R7

endmodule

// File: rtl/brg_counter.sv
module brg_counter
    import brg_pkg::*;
#(
    parameter int TC_W = 16,
    localparam int CNT_W = TC_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TC_W-1:0] tc,
    input  logic            run_en,
    input  logic            tick,
    input  logic            zero_ie,
    output logic            brg_clk,
    output logic            zero_evt,
    output logic            zero_irq
);

    brg_state_e        state_q;
    brg_state_e        state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  reload;
    logic              brg_q;
    logic              evt_q;
    logic              irq_q;

    assign reload = CNT_W'(tc) + CNT_W'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // transitions: start, go, count, stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: state_d = run_en ? ST_LOAD : ST_HOLD;
            ST_LOAD: state_d = run_en ? ST_RUN  : ST_HOLD;
            ST_RUN:  state_d = run_en ? ST_RUN  : ST_HOLD;
            default: state_d = ST_HOLD;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            brg_q <= 1'b0;
            evt_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            evt_q <= 1'b0;
            irq_q <= 1'b0;
            unique case (state_q)
                ST_HOLD: ;
                ST_LOAD: begin
                    if (run_en) cnt_q <= reload;
                end
                ST_RUN: begin
                    if (run_en && tick) begin
                        if (cnt_q == '0) begin
                            cnt_q <= reload;
                            brg_q <= ~brg_q;
                            evt_q <= 1'b1;
                            irq_q <= zero_ie;
                        end else begin
                            cnt_q <= cnt_q - CNT_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign brg_clk  = brg_q;
    assign zero_evt = evt_q;
    assign zero_irq = irq_q;

    AST_EVENT_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> brg_q != $past(brg_q)); // R2
    AST_QUIET_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_q |-> $stable(brg_q)); // R2
    AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> !evt_q); // R4
    AST_LOAD_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |-> $past(state_q) == ST_HOLD); // R5
    AST_EVENT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |=> !evt_q); // R8

endmodule

// File: rtl/baud_tc_gen.sv
module baud_tc_gen #(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              brg_clk_o,
    output logic              zero_pulse_o,
    output logic              irq_o
);

    localparam int TC_W = 2 * DATA_W;

    logic [TC_W-1:0] tc;
    logic            run_en;
    logic            src_sys;
    logic            zero_ie;
    logic            tick;

    brg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .zero_evt(zero_pulse_o),
        .rd_data (rd_data),
        .tc      (tc),
        .run_en  (run_en),
        .src_sys (src_sys),
        .zero_ie (zero_ie)
    );

    brg_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_clk(ext_clk),
        .src_sys(src_sys),
        .tick   (tick)
    );

    brg_counter #(.TC_W(TC_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tc      (tc),
        .run_en  (run_en),
        .tick    (tick),
        .zero_ie (zero_ie),
        .brg_clk (brg_clk_o),
        .zero_evt(zero_pulse_o),
        .zero_irq(irq_o)
    );

    AST_IRQ_WITH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> zero_pulse_o); // R9

endmodule

// File: tb/test_baud_tc_gen.sv
`timescale 1ns/100ps
module test_baud_tc_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       brg_clk_o;
    logic       zero_pulse_o;
    logic       irq_o;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    longint cyc = 0;

    localparam int EXT_DIV = 6;

    always #2.5 clk = ~clk;
    always #15 ext_clk = ~ext_clk;
    always @(posedge clk) cyc <= cyc + 1;

    baud_tc_gen i_baud_tc_gen (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .brg_clk_o(brg_clk_o), .zero_pulse_o(zero_pulse_o), .irq_o(irq_o)
    );

    function automatic longint exp_half(input int tc, input int div);
        return longint'(tc + 2) * div;
    endfunction

    function automatic int exp_first(input int tc);
        return tc + 4;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        rd_addr = 4'(a);
        #1;
        check(req, rd_data, exp);
    endtask

    // returns cycle stamp at the negedge where an event is seen
    task automatic wait_pulse(input string req, output longint stamp);
        stamp = 0;
        for (int i = 0; i < 140000; i++) begin
            @(negedge clk);
            if (zero_pulse_o) begin
                stamp = cyc;
                return;
            end
        end
        check({req, " timeout"}, 0, 1);
    endtask

    task automatic set_tc(input int tc);
        wr(12, tc & 8'hFF);
        wr(13, (tc >> 8) & 8'hFF);
    endtask

    // restart with a fresh constant, source sys (1) or ext (0), check first event
    task automatic restart(input int tc, input bit sys);
        longint t0, t1;
        wr(14, 2);
        set_tc(tc);
        wr(14, sys ? 3 : 1);
        t0 = cyc;
        wait_pulse("R5", t1);
        if (sys) check("R5 first event delay", t1 - t0, exp_first(tc));
    endtask

    task automatic meas_half(input string req, input int tc, input int div);
        longint a, b;
        wait_pulse(req, a);
        wait_pulse(req, b);
        check(req, b - a, exp_half(tc, div));
    endtask

    task automatic meas_full(input int tc);
        longint r0, r1, f0;
        bit prev;
        r0 = 0; r1 = 0; f0 = 0;
        prev = brg_clk_o;
        for (int i = 0; i < 2000 && r1 == 0; i++) begin
            @(negedge clk);
            if (!prev && brg_clk_o) begin
                if (r0 == 0) r0 = cyc; else r1 = cyc;
            end
            if (prev && !brg_clk_o && r0 != 0 && f0 == 0) f0 = cyc;
            prev = brg_clk_o;
        end
        check("R2 full period", r1 - r0, 2 * exp_half(tc, 1));
        check("R2 high time", f0 - r0, exp_half(tc, 1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        longint a, b, t;
        int tc, v;
        bit lvl;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10 brg_clk", brg_clk_o, 0);
        check("R10 pulse", zero_pulse_o, 0);
        rd_chk("R10 status", 0, 0);
        rd_chk("R10 tc lo", 12, 0);
        rd_chk("R10 tc hi", 13, 0);
        rd_chk("R10 ctrl", 14, 0);
        rd_chk("R10 ie", 15, 0);

        // R1 readback with random values, run bit kept clear
        for (int k = 0; k < 6; k++) begin
            int lo, hi, c, e;
            lo = $urandom_range(0, 255); hi = $urandom_range(0, 255);
            c = $urandom_range(0, 255) & 8'hFE; e = $urandom_range(0, 255);
            wr(12, lo); wr(13, hi); wr(14, c); wr(15, e);
            rd_chk("R1 tc lo", 12, lo);
            rd_chk("R1 tc hi", 13, hi);
            rd_chk("R1 ctrl", 14, c & 3);
            rd_chk("R1 ie", 15, e & 2);
            rd_chk("R1 unmapped", $urandom_range(1, 11), 0);
            check("R4 no event while off", zero_pulse_o, 0);
        end
        wr(15, 0);

        // R3 TC = 0
        restart(0, 1);
        meas_half("R3 tc0 half", 0, 1);
        meas_full(0);

        // TC = 1
        restart(1, 1);
        meas_half("R2 tc1 half", 1, 1);

        // R2 random constants
        for (int k = 0; k < 6; k++) begin
            tc = $urandom_range(0, 40);
            restart(tc, 1);
            meas_half("R2 half", tc, 1);
            meas_full(tc);
        end

        // R8 and R9
        restart(5, 1);
        wr(15, 2);
        wait_pulse("R9", t);
        check("R9 irq with enable", irq_o, 1);
        rd_chk("R8 status at event", 0, 2);
        @(negedge clk);
        check("R8 pulse one cycle", zero_pulse_o, 0);
        rd_chk("R8 status after event", 0, 0);
        check("R9 irq one cycle", irq_o, 0);
        wr(15, 0);
        wait_pulse("R9", t);
        check("R9 irq masked", irq_o, 0);

        // R6 write mid-countdown applies at next reload
        restart(10, 1);
        wait_pulse("R6", a);
        set_tc(20);
        wait_pulse("R6", b);
        check("R6 current countdown", b - a, exp_half(10, 1));
        wait_pulse("R6", t);
        check("R6 new constant", t - b, exp_half(20, 1));

        // R4 hold
        restart(3, 1);
        wr(14, 2);
        @(negedge clk);
        @(negedge clk);
        lvl = brg_clk_o;
        v = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (zero_pulse_o || brg_clk_o != lvl) v++;
        end
        check("R4 held while off", v, 0);

        // R7 external source
        restart(1, 0);
        meas_half("R7 ext tc1", 1, EXT_DIV);
        tc = $urandom_range(0, 6);
        restart(tc, 0);
        meas_half("R7 ext random", tc, EXT_DIV);
        restart(0, 0);
        meas_half("R7 ext tc0", 0, EXT_DIV);

        // R3 large constant
        wr(14, 2);
        set_tc(16'hFFFE);
        wr(14, 3);
        wait_pulse("R3", a);
        lvl = brg_clk_o;
        wait_pulse("R3", b);
        check("R3 tc FFFE half", b - a, exp_half(16'hFFFE, 1));
        check("R3 toggled", brg_clk_o, !lvl);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule